// File: doc/BRIEF.md
# Store Buffer with Load Ordering Check

This block keeps the stores of a speculative core between allocation and their write to memory. Each store gets an ID at allocation, in program order. The address half and the data half of the store then arrive as two separate writes, in any order. When a store retires, the block marks it committed. Committed stores leave for memory oldest first, but only while the bus is idle or every entry is in use.

Each load that is issued is looked up in the same cycle against the stores that were allocated before it. The load carries, as its tag, the allocation ID that was on offer when the load was issued. The lookup returns one of three answers:
- no conflict;
- forwarded data from the youngest conflicting older store;
- block, so the load is retried later.

A flush discards every store that has not yet committed. Allocation then resumes just past the last committed store.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_id` is 0, `mem_wvalid` is 0 and a lookup reports no hit.
- R2: `alloc_id` hands out pointers in order. Bits [3:0] count the index from 0 to DEPTH-1, and bit 4 toggles each time the index wraps back to 0. When DEPTH entries are held, `alloc_gnt` stays 0 and the pointer does not move.
- R3: A load is compared only against stores that were allocated before its tag, that is, IDs that precede `ld_tag` in allocation order.
- R4: A store covers the bytes [addr, addr + 2^size). A load conflicts with a store only when their byte ranges overlap. Ranges that only touch do not conflict.
- R5: The block forwards in one case only: the youngest conflicting older store has the same start address, a size at least the load size, and its data written. Then `ld_hit` and `ld_fwd` are 1, and `ld_data` holds the low 2^ld_size bytes of the store data with all upper bytes zero.
- R6: Any other conflict gives `ld_block`=1 and `ld_fwd`=0. So does any older store whose address has not been written.
- R7: Each cycle with `ret_valid` commits the oldest uncommitted store.
- R8: Committed stores appear on the memory port oldest first, one per cycle, in the same cycle in which the drain condition holds. The condition is that `mem_idle` is 1 or the buffer is full.
- R9: `flush` discards all uncommitted stores. `alloc_id` returns to the pointer just past the last committed store, and committed stores still drain.
- R10: With `ld_valid`=0, `ld_hit`, `ld_fwd`, `ld_block` and `ld_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request a new store entry |
| alloc_gnt | output | 1 | Entry granted this cycle |
| alloc_id | output | 5 | Next store ID (wrap bit + index) |
| sta_valid | input | 1 | Store address write |
| sta_id | input | 4 | Entry index for the address write |
| sta_addr | input | 16 | Store byte address |
| sta_size | input | 2 | Store size, 2^size bytes |
| std_valid | input | 1 | Store data write |
| std_id | input | 4 | Entry index for the data write |
| std_data | input | 64 | Store data |
| ld_valid | input | 1 | Load lookup valid |
| ld_tag | input | 5 | Allocation ID seen when the load was issued |
| ld_addr | input | 16 | Load byte address |
| ld_size | input | 2 | Load size, 2^size bytes |
| ld_hit | output | 1 | Load conflicts with an older store |
| ld_fwd | output | 1 | Data forwarded |
| ld_block | output | 1 | Load must retry |
| ld_data | output | 64 | Forwarded data |
| ret_valid | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Discard uncommitted stores |
| mem_idle | input | 1 | Memory bus idle |
| mem_wvalid | output | 1 | Memory write this cycle |
| mem_waddr | output | 16 | Memory write address |
| mem_wsize | output | 2 | Memory write size |
| mem_wdata | output | 64 | Memory write data |

## Verification
The bench builds the block with its default values: 12 entries, 16-bit addresses and 64-bit data. With 12 entries, filling the buffer carries the pointer across its wrap, so the toggled wrap bit and the full-buffer drain rule are both exercised in one short run. The 64-bit data path allows every size from one byte to eight bytes. That makes it possible to test the case where a load is larger than the store, and the case where only the low bytes of the store data are forwarded.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Linear position of a pointer in a space of 2*depth values.
  function automatic int unsigned sb_ord(input logic wrap, input int unsigned idx,
                                         input int unsigned depth);
    return wrap ? depth + idx : idx;
  endfunction

  // Distance from base forward to x, modulo 2*depth.
  function automatic int unsigned sb_dist(input int unsigned x, input int unsigned base,
                                          input int unsigned depth);
    return (x >= base) ? x - base : x + 2 * depth - base;
  endfunction

  function automatic int unsigned sb_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction

  function automatic logic sb_overlap(input int unsigned a, input logic [1:0] asz,
                                      input int unsigned b, input logic [1:0] bsz);
    return (a < b + sb_bytes(bsz)) && (b < a + sb_bytes(asz));
  endfunction

  function automatic logic sb_can_fwd(input int unsigned la, input logic [1:0] lsz,
                                      input int unsigned sa, input logic [1:0] ssz);
    return (la == sa) && (lsz <= ssz);
  endfunction
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl import sb_pkg::*; #(
  parameter int DEPTH = 12,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          ret_valid,
  input  logic          flush,
  input  logic          mem_idle,
  output logic [PW-1:0] head_q,
  output logic [PW-1:0] cpt_q,
  output logic [PW-1:0] tail_q,
  output logic [PW-1:0] used,
  output logic [PW-1:0] ccount,
  output logic          full,
  output logic          alloc_fire,
  output logic          commit_fire,
  output logic          drain_fire
);
  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    if (p[IW-1:0] == IW'(DEPTH - 1)) return {~p[PW-1], {IW{1'b0}}};
    return p + PW'(1);
  endfunction

  function automatic int unsigned ord(input logic [PW-1:0] p);
    return sb_ord(p[PW-1], int'(p[IW-1:0]), DEPTH);
  endfunction

  always_comb begin
    used        = PW'(sb_dist(ord(tail_q), ord(head_q), DEPTH));
    ccount      = PW'(sb_dist(ord(cpt_q), ord(head_q), DEPTH));
    full        = (used == PW'(DEPTH));
    alloc_fire  = alloc_req && !full && !flush;
    commit_fire = ret_valid && (cpt_q != tail_q) && !flush;
    drain_fire  = (ccount != '0) && (mem_idle || full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cpt_q  <= '0;
      tail_q <= '0;
    end else begin
      if (drain_fire)  head_q <= next_ptr(head_q);
      if (commit_fire) cpt_q  <= next_ptr(cpt_q);
      if (flush)           tail_q <= cpt_q;
      else if (alloc_fire) tail_q <= next_ptr(tail_q);
    end
  end
endmodule

// File: rtl/sb_entry_array.sv
module sb_entry_array #(
  parameter int DEPTH = 12,
  parameter int IW    = $clog2(DEPTH),
  parameter int AW    = 16,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic [IW-1:0] alloc_idx,
  input  logic          sta_valid,
  input  logic [IW-1:0] sta_idx,
  input  logic [AW-1:0] sta_addr,
  input  logic [1:0]    sta_size,
  input  logic          std_valid,
  input  logic [IW-1:0] std_idx,
  input  logic [DW-1:0] std_data,
  output logic          aok   [DEPTH],
  output logic          dok   [DEPTH],
  output logic [AW-1:0] addr_q[DEPTH],
  output logic [1:0]    size_q[DEPTH],
  output logic [DW-1:0] data_q[DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        aok[i]    <= 1'b0;
        dok[i]    <= 1'b0;
        addr_q[i] <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end else if (alloc_fire && alloc_idx == IW'(i)) begin
        aok[i] <= 1'b0;
        dok[i] <= 1'b0;
      end else begin
        if (sta_valid && sta_idx == IW'(i)) begin
          aok[i]    <= 1'b1;
          addr_q[i] <= sta_addr;
          size_q[i] <= sta_size;
        end
        if (std_valid && std_idx == IW'(i)) begin
          dok[i]    <= 1'b1;
          data_q[i] <= std_data;
        end
      end
    end
  end
endmodule

// File: rtl/sb_load_check.sv
module sb_load_check import sb_pkg::*; #(
  parameter int DEPTH = 12,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = IW + 1,
  parameter int AW    = 16,
  parameter int DW    = 64
) (
  input  logic [PW-1:0] head_q,
  input  logic [PW-1:0] used,
  input  logic          ld_valid,
  input  logic [PW-1:0] ld_tag,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic          aok   [DEPTH],
  input  logic          dok   [DEPTH],
  input  logic [AW-1:0] addr_q[DEPTH],
  input  logic [1:0]    size_q[DEPTH],
  input  logic [DW-1:0] data_q[DEPTH],
  output logic          ld_hit,
  output logic          ld_fwd,
  output logic          ld_block,
  output logic [DW-1:0] ld_data
);
  int unsigned   hidx, tpos, pos, bestpos, nbytes;
  logic          unk, found, fwd_ok;
  logic [IW-1:0] best;

  always_comb begin
    hidx    = int'(head_q[IW-1:0]);
    tpos    = sb_dist(sb_ord(ld_tag[PW-1], int'(ld_tag[IW-1:0]), DEPTH),
                      sb_ord(head_q[PW-1], hidx, DEPTH), DEPTH);
    // A tag behind the oldest held store has no older stores left.
    if (tpos > int'(used)) tpos = 0;
    unk     = 1'b0;
    found   = 1'b0;
    best    = '0;
    bestpos = 0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = (i >= int'(hidx)) ? i - hidx : i + DEPTH - hidx;
      if (pos < tpos) begin
        if (!aok[i]) unk = 1'b1;
        else if (sb_overlap(32'(ld_addr), ld_size, 32'(addr_q[i]), size_q[i]) &&
                 (!found || pos > bestpos)) begin
          found   = 1'b1;
          bestpos = pos;
          best    = IW'(i);
        end
      end
    end
    fwd_ok   = found && !unk && dok[best] &&
               sb_can_fwd(32'(ld_addr), ld_size, 32'(addr_q[best]), size_q[best]);
    ld_hit   = ld_valid && (found || unk);
    ld_fwd   = ld_valid && fwd_ok;
    ld_block = ld_hit && !fwd_ok;
    nbytes   = sb_bytes(ld_size);
    ld_data  = '0;
    for (int b = 0; b < DW / 8; b++)
      if (ld_fwd && b < int'(nbytes)) ld_data[b*8 +: 8] = data_q[best][b*8 +: 8];
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int DEPTH = 12,
  parameter int AW    = 16,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic          alloc_gnt,
  output logic [PW-1:0] alloc_id,
  input  logic          sta_valid,
  input  logic [IW-1:0] sta_id,
  input  logic [AW-1:0] sta_addr,
  input  logic [1:0]    sta_size,
  input  logic          std_valid,
  input  logic [IW-1:0] std_id,
  input  logic [DW-1:0] std_data,
  input  logic          ld_valid,
  input  logic [PW-1:0] ld_tag,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  output logic          ld_hit,
  output logic          ld_fwd,
  output logic          ld_block,
  output logic [DW-1:0] ld_data,
  input  logic          ret_valid,
  input  logic          flush,
  input  logic          mem_idle,
  output logic          mem_wvalid,
  output logic [AW-1:0] mem_waddr,
  output logic [1:0]    mem_wsize,
  output logic [DW-1:0] mem_wdata
);
  logic [PW-1:0] head_q, cpt_q, tail_q, used, ccount;
  logic          full, alloc_fire, commit_fire, drain_fire;
  logic          aok[DEPTH], dok[DEPTH];
  logic [AW-1:0] addr_q[DEPTH];
  logic [1:0]    size_q[DEPTH];
  logic [DW-1:0] data_q[DEPTH];

  sb_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk, .rst_n, .alloc_req, .ret_valid, .flush, .mem_idle,
    .head_q, .cpt_q, .tail_q, .used, .ccount, .full,
    .alloc_fire, .commit_fire, .drain_fire
  );

  sb_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) ent_i (
    .clk, .rst_n, .alloc_fire, .alloc_idx(tail_q[IW-1:0]),
    .sta_valid, .sta_idx(sta_id), .sta_addr, .sta_size,
    .std_valid, .std_idx(std_id), .std_data,
    .aok, .dok, .addr_q, .size_q, .data_q
  );

  sb_load_check #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
    .head_q, .used, .ld_valid, .ld_tag, .ld_addr, .ld_size,
    .aok, .dok, .addr_q, .size_q, .data_q,
    .ld_hit, .ld_fwd, .ld_block, .ld_data
  );

  assign alloc_gnt  = alloc_fire;
  assign alloc_id   = tail_q;
  assign mem_wvalid = drain_fire;
  assign mem_waddr  = addr_q[head_q[IW-1:0]];
  assign mem_wsize  = size_q[head_q[IW-1:0]];
  assign mem_wdata  = data_q[head_q[IW-1:0]];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH = 12,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_gnt,
  input logic          flush,
  input logic          ld_fwd,
  input logic          ld_block,
  input logic          mem_wvalid,
  input logic          mem_idle,
  input logic [PW-1:0] used,
  input logic [PW-1:0] ccount,
  input logic [PW-1:0] cpt_q,
  input logic [PW-1:0] tail_q
);
  // R2
  used_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));

  // R2
  grant_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !mem_wvalid) |=> used == $past(used) + PW'(1));

  // R6
  fwd_block_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_fwd && ld_block));

  // R8
  drain_committed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> ccount != '0);

  // R8
  busy_drain_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_idle) |-> used == PW'(DEPTH));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cpt_q == tail_q);
endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .PW(PW)) sva_i (
  .clk(clk), .rst_n(rst_n), .alloc_gnt(alloc_gnt), .flush(flush),
  .ld_fwd(ld_fwd), .ld_block(ld_block), .mem_wvalid(mem_wvalid),
  .mem_idle(mem_idle), .used(used), .ccount(ccount),
  .cpt_q(cpt_q), .tail_q(tail_q)
);

// File: tb/store_buffer_tb.sv
module store_buffer_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        alloc_req = 0, alloc_gnt;
  logic [4:0]  alloc_id;
  logic        sta_valid = 0, std_valid = 0, ld_valid = 0;
  logic [3:0]  sta_id = 0, std_id = 0;
  logic [15:0] sta_addr = 0, ld_addr = 0, mem_waddr;
  logic [1:0]  sta_size = 0, ld_size = 0, mem_wsize;
  logic [63:0] std_data = 0, ld_data, mem_wdata;
  logic [4:0]  ld_tag = 0;
  logic        ld_hit, ld_fwd, ld_block;
  logic        ret_valid = 0, flush = 0, mem_idle = 0, mem_wvalid;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  store_buffer dut_i (.*);

  typedef struct packed {
    logic [15:0] a; logic [1:0] sz; logic [4:0] tag;
    logic h; logic f; logic b; logic [63:0] d;
  } vec_t;

  // Stores: id0 @0x100 4B, id1 @0x108 8B, id2 @0x200 2B without data.
  localparam vec_t VEC[12] = '{
    '{16'h100, 2'd2, 5'd3, 1'b1, 1'b1, 1'b0, 64'h11223344},          // R5
    '{16'h100, 2'd0, 5'd3, 1'b1, 1'b1, 1'b0, 64'h44},                // R5
    '{16'h100, 2'd3, 5'd3, 1'b1, 1'b0, 1'b1, 64'h0},                 // R6
    '{16'h102, 2'd0, 5'd3, 1'b1, 1'b0, 1'b1, 64'h0},                 // R6
    '{16'h104, 2'd2, 5'd3, 1'b0, 1'b0, 1'b0, 64'h0},                 // R4
    '{16'h10C, 2'd1, 5'd3, 1'b1, 1'b0, 1'b1, 64'h0},                 // R6
    '{16'h108, 2'd3, 5'd3, 1'b1, 1'b1, 1'b0, 64'hAABBCCDDEEFF0011},  // R5
    '{16'h108, 2'd3, 5'd1, 1'b0, 1'b0, 1'b0, 64'h0},                 // R3
    '{16'h200, 2'd1, 5'd3, 1'b1, 1'b0, 1'b1, 64'h0},                 // R6
    '{16'h200, 2'd1, 5'd2, 1'b0, 1'b0, 1'b0, 64'h0},                 // R3
    '{16'h0FE, 2'd1, 5'd3, 1'b0, 1'b0, 1'b0, 64'h0},                 // R4
    '{16'h0FF, 2'd1, 5'd3, 1'b1, 1'b0, 1'b1, 64'h0}                  // R4
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_alloc(input logic [4:0] exp_id, input string req);
    alloc_req = 1; #1;
    check(alloc_gnt && alloc_id == exp_id, req, {58'b0, alloc_gnt, alloc_id}, {58'b0, 1'b1, exp_id});
    cyc(); alloc_req = 0;
  endtask

  task automatic wr_sta(input logic [3:0] id, input logic [15:0] a, input logic [1:0] sz);
    sta_valid = 1; sta_id = id; sta_addr = a; sta_size = sz;
    cyc(); sta_valid = 0;
  endtask

  task automatic wr_std(input logic [3:0] id, input logic [63:0] d);
    std_valid = 1; std_id = id; std_data = d;
    cyc(); std_valid = 0;
  endtask

  task automatic lookup(input logic [15:0] a, input logic [1:0] sz, input logic [4:0] tag,
                        input logic h, f, b, input logic [63:0] d, input string req);
    ld_valid = 1; ld_addr = a; ld_size = sz; ld_tag = tag; #1;
    check({ld_hit, ld_fwd, ld_block} == {h, f, b}, req,
          {61'b0, ld_hit, ld_fwd, ld_block}, {61'b0, h, f, b});
    check(ld_data == d, req, ld_data, d);
    ld_valid = 0;
    cyc();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    cyc();
    // R1 reset state
    check(alloc_id == 0, "R1", {59'b0, alloc_id}, 0);
    check(mem_wvalid == 0, "R1", {63'b0, mem_wvalid}, 0);
    lookup(16'h100, 2'd2, 5'd0, 0, 0, 0, 0, "R1");

    do_alloc(5'd0, "R2"); do_alloc(5'd1, "R2"); do_alloc(5'd2, "R2");
    wr_sta(0, 16'h100, 2'd2); wr_std(0, 64'h11223344);
    wr_sta(1, 16'h108, 2'd3); wr_std(1, 64'hAABBCCDDEEFF0011);
    wr_sta(2, 16'h200, 2'd1);

    for (int k = 0; k < 12; k++)
      lookup(VEC[k].a, VEC[k].sz, VEC[k].tag, VEC[k].h, VEC[k].f, VEC[k].b, VEC[k].d, "R3-table");

    // R5 data arrives late; youngest conflicting store wins
    wr_std(2, 64'hBEEF);
    lookup(16'h200, 2'd1, 5'd3, 1, 1, 0, 64'hBEEF, "R5");
    do_alloc(5'd3, "R2");
    wr_sta(3, 16'h100, 2'd2); wr_std(3, 64'h55667788);
    lookup(16'h100, 2'd2, 5'd4, 1, 1, 0, 64'h55667788, "R5");

    // R6 older store with unknown address blocks
    do_alloc(5'd4, "R2");
    lookup(16'h300, 2'd0, 5'd5, 1, 0, 1, 0, "R6");
    lookup(16'h300, 2'd0, 5'd4, 0, 0, 0, 0, "R6");

    // R10 idle lookup port
    ld_valid = 0; ld_addr = 16'h100; ld_size = 2'd2; ld_tag = 5'd5; #1;
    check(!ld_hit && !ld_fwd && !ld_block && ld_data == 0, "R10", {61'b0, ld_hit, ld_fwd, ld_block}, 0);
    cyc();

    // R7 / R8 commit two, bus busy holds them, then drain in order
    ret_valid = 1; cyc(); cyc(); ret_valid = 0;
    check(mem_wvalid == 0, "R8", {63'b0, mem_wvalid}, 0);
    mem_idle = 1; #1;
    check(mem_wvalid && mem_waddr == 16'h100 && mem_wdata == 64'h11223344, "R7",
          {mem_wvalid, 47'b0, mem_waddr}, {1'b1, 47'b0, 16'h100});
    cyc();
    check(mem_wvalid && mem_waddr == 16'h108 && mem_wdata == 64'hAABBCCDDEEFF0011, "R8",
          {mem_wvalid, 47'b0, mem_waddr}, {1'b1, 47'b0, 16'h108});
    cyc();
    check(mem_wvalid == 0, "R8", {63'b0, mem_wvalid}, 0);
    mem_idle = 0;

    // R9 flush rewinds allocation past last committed store
    flush = 1; cyc(); flush = 0;
    check(alloc_id == 5'd2, "R9", {59'b0, alloc_id}, 2);
    lookup(16'h100, 2'd2, 5'd5, 0, 0, 0, 0, "R9");

    // R2 fill to full across the wrap
    for (int k = 0; k < 12; k++)
      do_alloc((k < 10) ? 5'(k + 2) : 5'(16 + k - 10), "R2");
    check(alloc_id == 5'h12, "R2", {59'b0, alloc_id}, 64'h12);
    alloc_req = 1; #1;
    check(alloc_gnt == 0, "R2", {63'b0, alloc_gnt}, 0);
    cyc(); alloc_req = 0;
    check(alloc_id == 5'h12, "R2", {59'b0, alloc_id}, 64'h12);

    // R8 full buffer drains while bus busy
    wr_sta(2, 16'h400, 2'd2); wr_std(2, 64'h99);
    ret_valid = 1; cyc(); ret_valid = 0;
    check(mem_wvalid && mem_waddr == 16'h400 && mem_wdata == 64'h99, "R8",
          {mem_wvalid, 47'b0, mem_waddr}, {1'b1, 47'b0, 16'h400});
    cyc();
    check(mem_wvalid == 0, "R8", {63'b0, mem_wvalid}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule